// File: doc/BRIEF.md
# Two-Way Page Translation Cache

This block caches recent page translations for 4 KB pages. It holds two independent arrays, one for instruction fetches and one for data accesses. Each array is split into sets, and each set has two ways and a single recency bit. A lookup is purely combinational. It takes an effective address, an access kind and a probe flag. In the same cycle it reports a hit, the physical address, a cache-inhibit/write-through flag, or a request to update the page's change bit.

After a page table walk elsewhere in the chip, the fill port installs the second word of the found page entry. An invalidate port removes every translation for the set an address maps to, in both arrays. Fills, invalidations and the state changes caused by lookups all take effect on the rising clock edge.

Top module: `tlb2way`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge), every way in both arrays is empty, so no lookup hits and no lookup reports a change-bit update.
- R2: The page tag is `ea[31:12]`. The set index is the low log2(SETS) bits of the tag, which is `ea[17:12]` for 64 sets. Two pages with different tags in the same set can be resident together, one in each way.
- R3: On a hit or a change-bit update, `lk_paddr` is `{word[31:12], lk_ea[11:0]}`, where `word` is the stored page-entry word. On a miss, `lk_paddr` is 0.
- R4: On a hit or a change-bit update, `lk_wi` is high when bit 6 or bit 5 of the stored word is set. It is 0 on a miss.
- R5: A lookup with `lk_kind` = 2 (fetch) searches the instruction array. Kinds 0 (read), 1 (write) and 3 search the data array. A fill goes to the instruction array when `fl_fetch` is 1 and to the data array otherwise.
- R6: A fill writes way 1 only when the set's recency bit is 0 and way 0 holds a valid tag. Otherwise it writes way 0. The recency bit then takes the number of the way that was written.
- R7: A hit in way 0 sets the set's recency bit to 0, and a hit in way 1 sets it to 1. These hits include probe hits.
- R8: A non-probe write (`lk_kind` = 1) that matches an entry whose change bit (word bit 7) is 0 raises `lk_upd_c` with `lk_hit` low. It leaves the recency bit unchanged and sets bit 7 of the stored word, so the same write on the next cycle is a plain hit.
- R9: With `lk_probe` high, a write that matches an entry whose change bit is clear is a plain hit and does not set the change bit. A fill with `fl_probe` high changes nothing.
- R10: An invalidate empties both ways of the set selected by `inv_ea`, in both arrays. Other sets are untouched. When an invalidate and a fill land in the same set and cycle, the invalidate wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_en | input | 1 | Lookup valid this cycle |
| lk_ea | input | 32 | Lookup effective address |
| lk_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| lk_probe | input | 1 | Probe access that raises no exception |
| lk_hit | output | 1 | Translation found, no update needed |
| lk_upd_c | output | 1 | Match found, but the change bit must be written back |
| lk_paddr | output | 32 | Translated physical address |
| lk_wi | output | 1 | Cache-inhibit or write-through page |
| fl_en | input | 1 | Install an entry |
| fl_fetch | input | 1 | Install into the instruction array |
| fl_probe | input | 1 | Fill comes from a probe, so it is dropped |
| fl_ea | input | 32 | Effective address of the installed page |
| fl_word | input | 32 | Second page-entry word |
| inv_en | input | 1 | Invalidate a set |
| inv_ea | input | 32 | Address selecting the set to invalidate |

## Verification
The recency bit cannot be seen at the ports. The only way to observe it is the choice of victim on a later fill. The stimulus fills one set with three, four and then five pages whose tags share the same low bits. It places hits in way 1 and in way 0 before each fill, so that only a correct recency update evicts the page that is expected to go. Lookups afterwards confirm which page left. The change-bit path is reached by installing a word with bit 7 clear and writing to it twice: once as a probe, which must stay a plain hit, and then normally, which must request the update exactly once.

// File: rtl/tlb2way.sv
module tlb2way #(
  parameter int SETS = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        lk_en,
  input  logic [31:0] lk_ea,
  input  logic [1:0]  lk_kind,
  input  logic        lk_probe,
  output logic        lk_hit,
  output logic        lk_upd_c,
  output logic [31:0] lk_paddr,
  output logic        lk_wi,
  input  logic        fl_en,
  input  logic        fl_fetch,
  input  logic        fl_probe,
  input  logic [31:0] fl_ea,
  input  logic [31:0] fl_word,
  input  logic        inv_en,
  input  logic [31:0] inv_ea
);
  localparam int IW = $clog2(SETS);
  localparam logic [31:0] EMPTY = 32'hFFFF_FFFF;

  logic [31:0] tag_q  [2][2][SETS];
  logic [31:0] word_q [2][2][SETS];
  logic        rec_q  [2][SETS];

  wire [IW-1:0] lk_set  = lk_ea[IW+11:12];
  wire          lk_arr  = (lk_kind == 2'd2);
  wire [31:0]   lk_tag  = {12'b0, lk_ea[31:12]};
  wire          m0      = (tag_q[lk_arr][0][lk_set] == lk_tag);
  wire          m1      = (tag_q[lk_arr][1][lk_set] == lk_tag);
  wire          lk_way  = !m0;
  wire          lk_any  = lk_en && (m0 || m1);
  wire [31:0]   lk_word = word_q[lk_arr][lk_way][lk_set];
  wire          need_c  = (lk_kind == 2'd1) && !lk_probe && !lk_word[7];

  assign lk_hit   = lk_any && !need_c;
  assign lk_upd_c = lk_any && need_c;
  assign lk_paddr = lk_any ? {lk_word[31:12], lk_ea[11:0]} : 32'd0;
  assign lk_wi    = lk_any && (lk_word[6] || lk_word[5]);

  wire [IW-1:0] fl_set = fl_ea[IW+11:12];
  wire          fl_vic = !rec_q[fl_fetch][fl_set] && (tag_q[fl_fetch][0][fl_set] != EMPTY);
  wire [IW-1:0] iv_set = inv_ea[IW+11:12];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < 2; a++)
        for (int s = 0; s < SETS; s++) begin
          rec_q[a][s]     <= 1'b0;
          tag_q[a][0][s]  <= EMPTY;
          tag_q[a][1][s]  <= EMPTY;
          word_q[a][0][s] <= 32'd0;
          word_q[a][1][s] <= 32'd0;
        end
    end else begin
      if (lk_any) begin
        if (need_c) word_q[lk_arr][lk_way][lk_set][7] <= 1'b1;
        else        rec_q[lk_arr][lk_set] <= lk_way;
      end
      if (fl_en && !fl_probe) begin
        tag_q[fl_fetch][fl_vic][fl_set]  <= {12'b0, fl_ea[31:12]};
        word_q[fl_fetch][fl_vic][fl_set] <= fl_word;
        rec_q[fl_fetch][fl_set]          <= fl_vic;
      end
      if (inv_en)
        for (int a = 0; a < 2; a++) begin
          tag_q[a][0][iv_set] <= EMPTY;
          tag_q[a][1][iv_set] <= EMPTY;
        end
    end
  end

  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit && !lk_upd_c);

  assert_fill_then_match_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fl_en && !fl_probe && !inv_en) && lk_en
     && lk_ea[31:12] == $past(fl_ea[31:12]) && ((lk_kind == 2'd2) == $past(fl_fetch)))
    |-> (lk_hit || lk_upd_c) && lk_paddr[31:12] == $past(fl_word[31:12]));

  assert_invalidate_misses_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inv_en) && lk_en && lk_ea[IW+11:12] == $past(inv_ea[IW+11:12]))
    |-> !lk_hit && !lk_upd_c);

  assert_change_once_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lk_upd_c && !fl_en && !inv_en) && lk_en && lk_kind == 2'd1
     && !lk_probe && lk_ea[31:12] == $past(lk_ea[31:12]))
    |-> lk_hit);
endmodule

// File: tb/tlb2way_bench.sv
module tlb2way_bench;
  localparam int PERIOD = 10;

  logic clk = 0, rst = 1;
  logic lk_en = 0, lk_probe = 0, fl_en = 0, fl_fetch = 0, fl_probe = 0, inv_en = 0;
  logic [1:0] lk_kind = 0;
  logic [31:0] lk_ea = 0, fl_ea = 0, fl_word = 0, inv_ea = 0;
  logic lk_hit, lk_upd_c, lk_wi;
  logic [31:0] lk_paddr;

  typedef struct {
    logic hit; logic upd; logic [31:0] pa; logic wi; string req;
  } exp_t;
  exp_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  tlb2way u_tlb2way (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic clear_ops();
    lk_en = 0; fl_en = 0; inv_en = 0; lk_probe = 0; fl_probe = 0;
  endtask

  task automatic look(input [31:0] ea, input [1:0] kind, input bit probe,
                      input bit eh, input bit eu, input [31:0] epa, input bit ewi, input string req);
    exp_t e;
    @(negedge clk);
    clear_ops();
    lk_en = 1; lk_ea = ea; lk_kind = kind; lk_probe = probe;
    e.hit = eh; e.upd = eu; e.pa = epa; e.wi = ewi; e.req = req;
    sb.push_back(e);
    @(posedge clk);
  endtask

  task automatic fill(input [31:0] ea, input bit fetch, input bit probe, input [31:0] w);
    @(negedge clk);
    clear_ops();
    fl_en = 1; fl_ea = ea; fl_fetch = fetch; fl_probe = probe; fl_word = w;
    @(posedge clk);
  endtask

  task automatic inval(input [31:0] ea);
    @(negedge clk);
    clear_ops();
    inv_en = 1; inv_ea = ea;
    @(posedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      if (lk_en && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (lk_hit !== e.hit || lk_upd_c !== e.upd || lk_paddr !== e.pa || lk_wi !== e.wi) begin
          errors++;
          $display("FAIL %s: got hit=%b upd=%b pa=%h wi=%b, expected hit=%b upd=%b pa=%h wi=%b",
                   e.req, lk_hit, lk_upd_c, lk_paddr, lk_wi, e.hit, e.upd, e.pa, e.wi);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1: empty after reset
    look(32'h0000_5123, 2'd0, 0, 0, 0, 0, 0, "R1 data miss");
    look(32'h0000_5123, 2'd2, 0, 0, 0, 0, 0, "R1 fetch miss");
    // R2/R3: data fill, read hit
    fill(32'h0000_5000, 0, 0, 32'hAAAA_A080);
    look(32'h0000_5ABC, 2'd0, 0, 1, 0, 32'hAAAA_AABC, 0, "R3 read hit paddr");
    // R5: fetch does not see data array
    look(32'h0000_5ABC, 2'd2, 0, 0, 0, 0, 0, "R5 fetch misses data entry");
    // R4/R5: instruction fill with WI bits
    fill(32'h0000_5000, 1, 0, 32'hBBBB_B060);
    look(32'h0000_5010, 2'd2, 0, 1, 0, 32'hBBBB_B010, 1, "R4 R5 fetch hit wi");
    // R2/R6/R7: replacement in data set 5
    fill(32'h0004_5000, 0, 0, 32'h1111_1080);               // way1, rec=1
    look(32'h0000_5004, 2'd0, 0, 1, 0, 32'hAAAA_A004, 0, "R2 way0 resident");
    look(32'h0004_5008, 2'd0, 0, 1, 0, 32'h1111_1008, 0, "R2 way1 resident");
    fill(32'h0008_5000, 0, 0, 32'h2222_20A0);               // rec=1 -> way0
    look(32'h0000_5004, 2'd0, 0, 0, 0, 0, 0, "R6 A evicted");
    look(32'h0008_500C, 2'd0, 0, 1, 0, 32'h2222_200C, 1, "R4 R6 C in way0");
    look(32'h0004_5000, 2'd0, 0, 1, 0, 32'h1111_1000, 0, "R7 hit way1");
    fill(32'h000C_5000, 0, 0, 32'h3333_3080);               // rec=1 -> way0
    look(32'h0008_5000, 2'd0, 0, 0, 0, 0, 0, "R7 way1 hit protected B, C evicted");
    look(32'h0004_5000, 2'd0, 0, 1, 0, 32'h1111_1000, 0, "R7 B still resident");
    look(32'h000C_5000, 2'd0, 0, 1, 0, 32'h3333_3000, 0, "R7 hit way0");
    fill(32'h0010_5000, 0, 0, 32'h4444_4080);               // rec=0 -> way1
    look(32'h0004_5000, 2'd0, 0, 0, 0, 0, 0, "R7 way0 hit made B victim");
    look(32'h000C_5FFF, 2'd0, 0, 1, 0, 32'h3333_3FFF, 0, "R6 D kept");
    look(32'h0010_5001, 2'd0, 0, 1, 0, 32'h4444_4001, 0, "R6 E installed");
    // R8: change bit
    fill(32'h0000_7000, 0, 0, 32'h5555_5000);
    look(32'h0000_7010, 2'd1, 0, 0, 1, 32'h5555_5010, 0, "R8 update request");
    look(32'h0000_7010, 2'd1, 0, 1, 0, 32'h5555_5010, 0, "R8 second write hits");
    // R9: probe write and probe fill
    fill(32'h0000_8000, 0, 0, 32'h6666_6000);
    look(32'h0000_8020, 2'd1, 1, 1, 0, 32'h6666_6020, 0, "R9 probe write plain hit");
    look(32'h0000_8020, 2'd1, 0, 0, 1, 32'h6666_6020, 0, "R9 probe left C clear");
    fill(32'h0000_9000, 0, 1, 32'h7777_7000);
    look(32'h0000_9000, 2'd0, 0, 0, 0, 0, 0, "R9 probe fill dropped");
    // R10: invalidate set 5
    inval(32'h0000_5FFF);
    look(32'h000C_5000, 2'd0, 0, 0, 0, 0, 0, "R10 way0 cleared");
    look(32'h0010_5000, 2'd0, 0, 0, 0, 0, 0, "R10 way1 cleared");
    look(32'h0000_5000, 2'd2, 0, 0, 0, 0, 0, "R10 instruction array cleared");
    look(32'h0000_7010, 2'd0, 0, 1, 0, 32'h5555_5010, 0, "R10 other set kept");
    @(negedge clk);
    clear_ops();
    repeat (2) @(posedge clk);
    done = 1;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending, expected 0", sb.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule